// File: doc/BRIEF.md
# Pin-Change Interrupt Detector

This block watches a bank of already synchronised and filtered pin levels and turns selected activity on them into pending interrupt status. In its default setting every pin reports any change of level. A pin can be switched, one pin at a time, into an alternate detection mode. In that mode a polarity select and a type select choose between a rising edge, a falling edge, a high level and a low level.

Software-side logic drives write strobes that share one bit mask. Separate strobes set and clear the alternate mode, the polarity, the detection type and the interrupt enable. The status register is presented in every cycle. Asserting the read strobe consumes it: the bits shown in that cycle are cleared at the next clock edge. A single interrupt line is raised while any status bit is pending on an enabled pin.

Top module: `pinchg_irq_ctrl`

## Requirements
- R1: Reset (synchronous, active low) has these effects: status reads 0, the enable mask reads 0, the interrupt line is low, every pin is in the default any-change mode with polarity low and type edge, and the first pin sample taken after reset raises no event.
- R2: For a pin in the default mode, a level that differs from the previous sample sets that pin's status bit at the clock edge where the new level is first sampled. Any number of pins may do this together.
- R3: For a pin in alternate mode with polarity high and type edge, only a 0-to-1 transition sets its status bit.
- R4: For a pin in alternate mode with polarity low and type edge, only a 1-to-0 transition sets its status bit.
- R5: For a pin in alternate mode with polarity high and type level, status is set at every edge where the pin samples 1, so a bit cleared by a read comes back on the next edge while the level persists.
- R6: For a pin in alternate mode with polarity low and type level, status is set at every edge where the pin samples 0.
- R7: The alternate-mode enable and disable strobes act only on the pins whose `cfg_mask` bit is 1. If both strobes are asserted in the same cycle, disable wins. A change takes effect for samples from the next edge on.
- R8: The polarity strobes (high and low) and the type strobes (edge and level) act only on masked pins. If both strobes of a pair are asserted together, low and level win. These selects have no effect while a pin is in the default mode.
- R9: The interrupt enable and disable strobes set and clear bits of `irq_mask` under `cfg_mask`, and the new value is visible after the edge. Disable wins when both strobes are asserted together.
- R10: Status bits are set whether or not the pin is enabled. `irq` is high exactly when some status bit and the same `irq_mask` bit are both 1.
- R11: `stat_q` shows the pending bits in the cycle of `stat_rd`. At the following edge those bits clear, except for bits that receive a new event at that same edge, which stay set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_lvl | input | NUM_PINS | Filtered, synchronised pin levels |
| cfg_mask | input | NUM_PINS | Pin selection shared by all write strobes |
| alt_en_wr | input | 1 | Put masked pins into alternate mode |
| alt_dis_wr | input | 1 | Return masked pins to any-change mode |
| pol_hi_wr | input | 1 | Select rising edge or high level |
| pol_lo_wr | input | 1 | Select falling edge or low level |
| type_edge_wr | input | 1 | Select edge detection |
| type_lvl_wr | input | 1 | Select level detection |
| irq_en_wr | input | 1 | Enable interrupt for masked pins |
| irq_dis_wr | input | 1 | Disable interrupt for masked pins |
| stat_rd | input | 1 | Read strobe that consumes the status |
| stat_q | output | NUM_PINS | Pending event status |
| irq_mask | output | NUM_PINS | Current interrupt enable mask |
| irq | output | 1 | Interrupt request |

## Verification
A level driven before clock edge k is compared with the sample taken at edge k-1 and lands in `stat_q` right after edge k. `irq` follows in the same cycle, because it is decoded from the status and mask registers. Mask strobes update `irq_mask` at their own edge. Mode and polarity strobes apply from the next sample on. Read data is the value present in the strobe cycle, and the clear shows after the following edge. The bench drives every input on the falling edge, keeps a cycle model of the status, mask and mode state, and compares all three outputs at the next falling edge. This puts each comparison exactly one register stage after the stimulus. It sweeps all 32 pins in the default mode and all four alternate modes over one pin pattern.

// File: rtl/pce_pkg.sv
// Shared definitions for the pin-change interrupt detector.
// Assumes: nothing beyond IEEE 1800-2017.
package pce_pkg;

    // Detection choice of one pin while its alternate mode is on:
    // bit 1 = level (1) or edge (0), bit 0 = high/rising (1) or low/falling (0)
    typedef enum logic [1:0] {
        DET_FALL_EDGE = 2'b00,
        DET_RISE_EDGE = 2'b01,
        DET_LOW_LVL   = 2'b10,
        DET_HIGH_LVL  = 2'b11
    } det_mode_e;

    // Next value of a set/clear register: clear has priority over set
    function automatic logic next_bit(input logic cur, input logic set_b, input logic clr_b);
        return (cur | set_b) & ~clr_b;
    endfunction

endpackage

// File: rtl/pce_setclr_reg.sv
// Bank of W flops written only through set and clear strobes qualified
// by a shared bit mask. Clear wins over set in the same cycle.
// Assumes: strobes are single-cycle, synchronous to clk.
module pce_setclr_reg
    import pce_pkg::*;
#(
    parameter int          W       = 32,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] bits_mask,
    output logic [W-1:0] q
);

    logic [W-1:0] set_v;
    logic [W-1:0] clr_v;

    // Qualify strobes with the pin mask
    always_comb begin
        set_v = set_stb ? bits_mask : '0;
        clr_v = clr_stb ? bits_mask : '0;
    end

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            // Hold, set or clear one configuration bit
            always_ff @(posedge clk) begin
                if (!rst_n) q[gi] <= RST_VAL[gi];
                else        q[gi] <= next_bit(q[gi], set_v[gi], clr_v[gi]);
            end
        end
    endgenerate

endmodule

// File: rtl/pce_event_det.sv
// Per-pin event detector. Keeps the previous sample of each pin and
// decodes any-change, edge or level events according to the pin's mode.
// Assumes: pin_lvl is already synchronised to clk; the first sample after
// reset only primes the history and yields no event.
module pce_event_det
    import pce_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_lvl,
    input  logic [W-1:0] alt_on,
    input  logic [W-1:0] pol_hi,
    input  logic [W-1:0] type_edge,
    output logic [W-1:0] ev
);

    logic [W-1:0] prev_lvl;
    logic         primed;

    // Remember the last sample of every pin
    always_ff @(posedge clk) begin
        if (!rst_n) prev_lvl <= '0;
        else        prev_lvl <= pin_lvl;
    end

    // Mark that a valid history sample exists
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_pin
            det_mode_e mode;
            logic      rise;
            logic      fall;
            logic      raw;

            // Decode this pin's event from its mode and history
            always_comb begin
                mode = det_mode_e'({~type_edge[gi], pol_hi[gi]});
                rise = pin_lvl[gi] & ~prev_lvl[gi];
                fall = ~pin_lvl[gi] & prev_lvl[gi];
                if (!alt_on[gi]) begin
                    raw = rise | fall;
                end else begin
                    unique case (mode)
                        DET_FALL_EDGE: raw = fall;
                        DET_RISE_EDGE: raw = rise;
                        DET_LOW_LVL:   raw = ~pin_lvl[gi];
                        DET_HIGH_LVL:  raw = pin_lvl[gi];
                        default:       raw = 1'b0;
                    endcase
                end
                ev[gi] = raw & primed;
            end
        end
    endgenerate

endmodule

// File: rtl/pce_status.sv
// Pending-status register with clear-on-read and the merged interrupt line.
// A read clears the bits shown in its cycle; events of the same edge survive.
// Assumes: stat_rd is a single-cycle strobe.
module pce_status #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev,
    input  logic         stat_rd,
    input  logic [W-1:0] mask_q,
    output logic [W-1:0] stat_q,
    output logic         irq
);

    logic [W-1:0] stat_d;

    // Next status: drop consumed bits, then add new events
    always_comb begin
        stat_d = (stat_rd ? '0 : stat_q) | ev;
    end

    // Hold pending status
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    // Raise the request for any enabled pending pin
    always_comb begin
        irq = |(stat_q & mask_q);
    end

endmodule

// File: rtl/pinchg_irq_ctrl.sv
// Top of the pin-change interrupt detector: four set/clear configuration
// banks, the per-pin event detector and the status/interrupt stage.
// Assumes: all strobes share cfg_mask and are synchronous to clk.
module pinchg_irq_ctrl
    import pce_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_lvl,
    input  logic [NUM_PINS-1:0] cfg_mask,
    input  logic                alt_en_wr,
    input  logic                alt_dis_wr,
    input  logic                pol_hi_wr,
    input  logic                pol_lo_wr,
    input  logic                type_edge_wr,
    input  logic                type_lvl_wr,
    input  logic                irq_en_wr,
    input  logic                irq_dis_wr,
    input  logic                stat_rd,
    output logic [NUM_PINS-1:0] stat_q,
    output logic [NUM_PINS-1:0] irq_mask,
    output logic                irq
);

    localparam logic [NUM_PINS-1:0] ALL_ZERO = '0;
    localparam logic [NUM_PINS-1:0] ALL_ONE  = '1;

    logic [NUM_PINS-1:0] alt_q;
    logic [NUM_PINS-1:0] pol_q;
    logic [NUM_PINS-1:0] typ_q;
    logic [NUM_PINS-1:0] ev_w;

    pce_setclr_reg #(.W(NUM_PINS), .RST_VAL(ALL_ZERO)) u_alt (
        .clk(clk), .rst_n(rst_n), .set_stb(alt_en_wr), .clr_stb(alt_dis_wr),
        .bits_mask(cfg_mask), .q(alt_q));

    pce_setclr_reg #(.W(NUM_PINS), .RST_VAL(ALL_ZERO)) u_pol (
        .clk(clk), .rst_n(rst_n), .set_stb(pol_hi_wr), .clr_stb(pol_lo_wr),
        .bits_mask(cfg_mask), .q(pol_q));

    pce_setclr_reg #(.W(NUM_PINS), .RST_VAL(ALL_ONE)) u_typ (
        .clk(clk), .rst_n(rst_n), .set_stb(type_edge_wr), .clr_stb(type_lvl_wr),
        .bits_mask(cfg_mask), .q(typ_q));

    pce_setclr_reg #(.W(NUM_PINS), .RST_VAL(ALL_ZERO)) u_msk (
        .clk(clk), .rst_n(rst_n), .set_stb(irq_en_wr), .clr_stb(irq_dis_wr),
        .bits_mask(cfg_mask), .q(irq_mask));

    pce_event_det #(.W(NUM_PINS)) u_det (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .alt_on(alt_q),
        .pol_hi(pol_q), .type_edge(typ_q), .ev(ev_w));

    pce_status #(.W(NUM_PINS)) u_stat (
        .clk(clk), .rst_n(rst_n), .ev(ev_w), .stat_rd(stat_rd),
        .mask_q(irq_mask), .stat_q(stat_q), .irq(irq));

endmodule

// File: rtl/pce_checker.sv
// Temporal checks on the pin-change interrupt detector, bound to its top.
// Assumes: ev is the detector output feeding the status stage.
module pce_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] cfg_mask,
    input logic         irq_en_wr,
    input logic         irq_dis_wr,
    input logic         stat_rd,
    input logic [W-1:0] ev,
    input logic [W-1:0] stat_q,
    input logic [W-1:0] irq_mask,
    input logic         irq
);

    p_mask_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en_wr && !irq_dis_wr) |=> ((irq_mask & $past(cfg_mask)) == $past(cfg_mask)));

    p_mask_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_dis_wr |=> ((irq_mask & $past(cfg_mask)) == '0));

    p_stat_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    p_read_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> ((stat_q & ~$past(ev)) == '0));

    p_event_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0) |=> ((stat_q & $past(ev)) == $past(ev)));

    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask == '0) |-> !irq);

endmodule

bind pinchg_irq_ctrl pce_checker #(.W(NUM_PINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_mask(cfg_mask), .irq_en_wr(irq_en_wr),
    .irq_dis_wr(irq_dis_wr), .stat_rd(stat_rd), .ev(ev_w), .stat_q(stat_q),
    .irq_mask(irq_mask), .irq(irq));

// File: tb/pinchg_irq_ctrl_tb.sv
module pinchg_irq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_lvl = '0;
    logic [31:0] cfg_mask = '0;
    logic alt_en_wr = 0, alt_dis_wr = 0, pol_hi_wr = 0, pol_lo_wr = 0;
    logic type_edge_wr = 0, type_lvl_wr = 0, irq_en_wr = 0, irq_dis_wr = 0;
    logic stat_rd = 0;
    logic [31:0] stat_q, irq_mask;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Bench model of the requirements
    logic [31:0] m_stat = '0, m_mask = '0, m_alt = '0, m_pol = '0;
    logic [31:0] m_typ = '1, m_prev = '0;
    bit          m_primed = 0;

    pinchg_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .cfg_mask(cfg_mask),
        .alt_en_wr(alt_en_wr), .alt_dis_wr(alt_dis_wr), .pol_hi_wr(pol_hi_wr),
        .pol_lo_wr(pol_lo_wr), .type_edge_wr(type_edge_wr), .type_lvl_wr(type_lvl_wr),
        .irq_en_wr(irq_en_wr), .irq_dis_wr(irq_dis_wr), .stat_rd(stat_rd),
        .stat_q(stat_q), .irq_mask(irq_mask), .irq(irq));

    always #4 clk = ~clk;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic clr_strobes();
        alt_en_wr = 0; alt_dis_wr = 0; pol_hi_wr = 0; pol_lo_wr = 0;
        type_edge_wr = 0; type_lvl_wr = 0; irq_en_wr = 0; irq_dis_wr = 0;
        stat_rd = 0; cfg_mask = '0;
    endtask

    // One clock: inputs are already set at a falling edge
    task automatic tick(input string tag);
        logic [31:0] ev;
        logic [31:0] sv;
        if (stat_rd) chk(tag, "read data", stat_q, m_stat);
        for (int i = 0; i < 32; i++) begin
            logic p, q;
            p = pin_lvl[i]; q = m_prev[i];
            if (!m_primed)        ev[i] = 1'b0;
            else if (!m_alt[i])   ev[i] = p ^ q;
            else if (m_typ[i])    ev[i] = m_pol[i] ? (p & ~q) : (~p & q);
            else                  ev[i] = m_pol[i] ? p : ~p;
        end
        m_stat = (stat_rd ? 32'h0 : m_stat) | ev;
        sv = cfg_mask;
        if (alt_en_wr)    m_alt  = m_alt | sv;
        if (alt_dis_wr)   m_alt  = m_alt & ~sv;
        if (pol_hi_wr)    m_pol  = m_pol | sv;
        if (pol_lo_wr)    m_pol  = m_pol & ~sv;
        if (type_edge_wr) m_typ  = m_typ | sv;
        if (type_lvl_wr)  m_typ  = m_typ & ~sv;
        if (irq_en_wr)    m_mask = m_mask | sv;
        if (irq_dis_wr)   m_mask = m_mask & ~sv;
        m_prev = pin_lvl;
        m_primed = 1;
        @(posedge clk);
        @(negedge clk);
        clr_strobes();
        chk(tag, "status", stat_q, m_stat);
        chk(tag, "mask", irq_mask, m_mask);
        chk(tag, "irq", {31'h0, irq}, {31'h0, |(m_stat & m_mask)});
    endtask

    task automatic rd_tick(input string tag);
        stat_rd = 1;
        tick(tag);
    endtask

    // Watchdog
    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        pin_lvl = 32'hA5A5_0F0F;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "status", stat_q, 32'h0);
        chk("R1", "mask", irq_mask, 32'h0);
        chk("R1", "irq", {31'h0, irq}, 32'h0);
        rst_n = 1;
        tick("R1 first sample");
        tick("R1");

        // R2: sweep every pin in default mode
        for (int i = 0; i < 32; i++) begin
            pin_lvl = pin_lvl ^ (32'h1 << i);
            tick("R2");
            rd_tick("R2");
        end
        pin_lvl = pin_lvl ^ 32'hFFFF_0000;
        tick("R2 multi");
        rd_tick("R2");
        pin_lvl = 32'h0;
        tick("R2");
        rd_tick("R2");

        // R3..R6: sweep the four alternate modes on pins 7:4
        for (int m = 0; m < 4; m++) begin
            string tg;
            tg = (m == 0) ? "R4" : (m == 1) ? "R3" : (m == 2) ? "R6" : "R5";
            cfg_mask = 32'h0000_00F0;
            alt_en_wr = 1;
            if (m[0]) pol_hi_wr = 1; else pol_lo_wr = 1;
            if (m[1]) type_lvl_wr = 1; else type_edge_wr = 1;
            tick("R7");
            rd_tick(tg);
            pin_lvl = 32'h0000_00FF; tick(tg);
            tick(tg);
            rd_tick(tg);
            pin_lvl = 32'h0; tick(tg);
            rd_tick(tg);
            tick(tg);
            rd_tick(tg);
            pin_lvl = 32'h0000_00FF; tick(tg);
            pin_lvl = 32'h0; tick(tg);
            rd_tick(tg);
        end

        // R7: partial disable returns pins 5:4 to any-change
        cfg_mask = 32'h0000_0030; alt_dis_wr = 1; tick("R7");
        rd_tick("R7");
        pin_lvl = 32'h0000_00F0; tick("R7");
        rd_tick("R7");
        pin_lvl = 32'h0; tick("R7");
        rd_tick("R7");
        // R7: simultaneous enable and disable leaves pins in default mode
        cfg_mask = 32'h0000_0300; alt_en_wr = 1; alt_dis_wr = 1; tick("R7 conflict");
        pin_lvl = 32'h0000_0300; tick("R7 conflict");
        rd_tick("R7");
        pin_lvl = 32'h0; tick("R7");
        rd_tick("R7");

        // R8: conflicting selects pick low level
        cfg_mask = 32'h0000_0C00; alt_en_wr = 1; pol_hi_wr = 1; pol_lo_wr = 1;
        type_edge_wr = 1; type_lvl_wr = 1; tick("R8 conflict");
        rd_tick("R8");
        tick("R8 low level");
        pin_lvl = 32'h0000_0C00; rd_tick("R8");
        tick("R8");
        // R8: selects without alternate mode have no effect
        cfg_mask = 32'h0000_3000; pol_hi_wr = 1; type_lvl_wr = 1; tick("R8");
        rd_tick("R8");
        tick("R8 no effect");
        pin_lvl = 32'h0000_3C00; tick("R8 no effect");
        rd_tick("R8");

        // R9 / R10: mask and interrupt line
        cfg_mask = 32'h0000_0F0F; irq_en_wr = 1; tick("R9");
        rd_tick("R10");
        pin_lvl = pin_lvl ^ 32'h0010_0000; tick("R10 unmasked event");
        pin_lvl = pin_lvl ^ 32'h0000_0002; tick("R10 masked event");
        rd_tick("R10");
        cfg_mask = 32'h0000_0001; irq_en_wr = 1; irq_dis_wr = 1; tick("R9 conflict");
        cfg_mask = 32'hFFFF_0000; irq_en_wr = 1; tick("R9");
        cfg_mask = 32'hFFFF_FFFF; irq_dis_wr = 1; tick("R9");

        // R11: event in the same cycle as a read survives
        pin_lvl = pin_lvl ^ 32'h0000_0004; tick("R11");
        pin_lvl = pin_lvl ^ 32'h0000_0004; rd_tick("R11 collide");
        rd_tick("R11");
        tick("R11");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule